// File: doc/BRIEF.md
# Instruction-Boundary Event Arbiter

This block sits beside an instruction pipeline and decides, once per instruction boundary, which asynchronous event the core services next. Each retire strobe marks a boundary. One cycle later the arbiter weighs the pending events against a fixed priority, the global interrupt gate and the one-instruction shadow left by a stack-segment load or an interrupt-enable instruction. It registers at most one action strobe. It then stays idle until the next retire strobe arrives.

Events are held internally. System-management, reset-init and non-maskable requests arrive as raise pulses and stay pending until they are taken. Maskable interrupts are the legacy request level and the local-controller pending level, both qualified by the interrupt-enable flag. Debug traps build up in an internal trap register: the instruction sets them at retire, and the trap flag adds the single-step bit. The register is cleared when a debug exception is taken, and also when an evaluation finds no trap to raise. A registered async-work flag tells the pipeline whether any of this state still needs a boundary check.

Top module: `evt_boundary_arbiter`

## Requirements
- R1: At most one of the eight action strobes is high in any cycle. A strobe appears exactly two clock edges after a sampled retire_i and lasts one cycle. Without a new retire_i, no further strobe follows.
- R2: Only one action is taken per boundary, in this priority: task-switch debug trap (trap bit 15); system-management entry; soft reset for init; debug trap; non-maskable interrupt; maskable acknowledge; hold grant.
- R3: System-management entry and init soft reset require gate_i=1. A gated request stays pending. Taking system-management entry clears its pending bit, and the soft reset clears init pending. init_raise_i has no effect while init_block_i is high.
- R4: With gate_i=0 at evaluation, every trap bit except single-step (bit 14) is discarded. Bit 15 is task switch, bits 13:12 are breakpoint matches and bits 11:0 are non-firing status.
- R5: Outside the debug shadow, a boundary with any trap bit 15:12 set raises dbg_exc_o and clears the trap register. A boundary with none of those bits set clears the register and goes on to interrupts.
- R6: Non-maskable interrupts, maskable interrupts and the hold grant are all blocked while the interrupt shadow is active or gate_i=0.
- R7: Taking the non-maskable interrupt clears its pending bit, masks further ones until nmi_unmask_i, and drives nmi_vec_o=2 with nmi_take_o.
- R8: A maskable interrupt needs if_i=1 and intr_i or lapic_pend_i. The acknowledge goes to ack_lapic_o if lapic_pend_i=1, otherwise to ack_legacy_o.
- R9: An inhibit request given with retire_i covers only the next boundary. A stack-segment load blocks both the interrupt class and the debug class. An interrupt-enable instruction blocks only the interrupt class.
- R10: A stack-segment-load request that retires while a stack-segment shadow is active is ignored, so the shadow ends. An interrupt-enable request does re-arm its shadow.
- R11: tf_i=1 at a boundary that takes no debug exception sets single-step bit 14, so the trap fires at the next boundary.
- R12: work_o is high one cycle after the state shows gated unmasked pending events (system-management, init, non-maskable, or maskable with if_i), any trap bit, or hold_req_i.
- R13: After rst all strobes, nmi_vec_o and work_o are 0, and nothing is pending or shadowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction retired; marks a boundary |
| ss_inh_i | input | 1 | Retiring instruction loaded the stack segment |
| sti_inh_i | input | 1 | Retiring instruction enabled interrupts |
| trap_set_i | input | TRAP_W | Trap bits raised by the retiring instruction |
| tf_i | input | 1 | Trap flag |
| if_i | input | 1 | Interrupt-enable flag |
| gate_i | input | 1 | Global interrupt gate |
| smi_raise_i | input | 1 | System-management request pulse |
| smi_block_i | input | 1 | System-management requests masked |
| init_raise_i | input | 1 | Init request pulse |
| init_block_i | input | 1 | Init requests masked |
| nmi_raise_i | input | 1 | Non-maskable request pulse |
| nmi_unmask_i | input | 1 | Re-enable non-maskable delivery |
| intr_i | input | 1 | Legacy controller interrupt request level |
| lapic_pend_i | input | 1 | Local controller interrupt pending level |
| hold_req_i | input | 1 | Bus hold request |
| dbg_exc_o | output | 1 | Raise debug exception |
| smm_enter_o | output | 1 | Enter system-management mode |
| soft_rst_o | output | 1 | Soft reset for init |
| nmi_take_o | output | 1 | Deliver non-maskable interrupt |
| nmi_vec_o | output | VEC_W | Vector delivered with nmi_take_o |
| ack_lapic_o | output | 1 | Acknowledge to local controller |
| ack_legacy_o | output | 1 | Acknowledge to legacy controller |
| hlda_o | output | 1 | Hold acknowledge |
| work_o | output | 1 | Asynchronous work pending |

## Verification
A corrupted pending or mask bit shows up as a wrong or missing strobe at the first boundary after the corruption. A stuck non-maskable mask, for example, silences nmi_take_o at once. A shadow that lasts too long or too short changes the strobe two edges after the retire that should have ended it or armed it. A trap register that is not cleared shows up as a spurious dbg_exc_o at the following boundary, and as work_o staying high one cycle after the state should have emptied.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
  typedef enum logic [2:0] {
    ACT_NONE, ACT_DBG, ACT_SMM, ACT_RST, ACT_NMI, ACT_ACK_LOC, ACT_ACK_LEG, ACT_HLDA
  } act_e;

  // inhibit classes and the masks each request installs
  localparam logic [1:0] CLS_INTR = 2'b01;
  localparam logic [1:0] CLS_DBG  = 2'b10;
  localparam logic [1:0] MASK_SS  = 2'b11;
  localparam logic [1:0] MASK_STI = 2'b01;

  function automatic logic class_hit(input logic live, input logic [1:0] mask,
                                     input logic [1:0] cls);
    return live && ((mask & cls) == cls);
  endfunction
endpackage

// File: rtl/evt_shadow.sv
module evt_shadow
  import evt_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic retire_i,
  input  logic ss_req_i,
  input  logic sti_req_i,
  output logic intr_blk_o,
  output logic dbg_blk_o
);
  logic       live_q;
  logic [1:0] mask_q;
  logic       ss_live;

  assign ss_live = class_hit(live_q, mask_q, MASK_SS);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      mask_q <= 2'b00;
    end else if (retire_i) begin
      if (ss_req_i && !ss_live) begin
        live_q <= 1'b1;
        mask_q <= MASK_SS;
      end else if (sti_req_i && !ss_req_i) begin
        live_q <= 1'b1;
        mask_q <= MASK_STI;
      end else begin
        live_q <= 1'b0;
      end
    end
  end

  assign intr_blk_o = class_hit(live_q, mask_q, CLS_INTR);
  assign dbg_blk_o  = class_hit(live_q, mask_q, CLS_DBG);
endmodule

// File: rtl/evt_pending.sv
module evt_pending
  import evt_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic smi_raise_i,
  input  logic smi_block_i,
  input  logic init_raise_i,
  input  logic init_block_i,
  input  logic nmi_raise_i,
  input  logic nmi_unmask_i,
  input  act_e taken_i,
  output logic smi_ok_o,
  output logic init_ok_o,
  output logic nmi_ok_o
);
  logic smi_p_q, init_p_q, nmi_p_q, nmi_m_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_p_q  <= 1'b0;
      init_p_q <= 1'b0;
      nmi_p_q  <= 1'b0;
      nmi_m_q  <= 1'b0;
    end else begin
      smi_p_q  <= (smi_p_q && taken_i != ACT_SMM) || smi_raise_i;
      init_p_q <= (init_p_q && taken_i != ACT_RST) || (init_raise_i && !init_block_i);
      nmi_p_q  <= (nmi_p_q && taken_i != ACT_NMI) || nmi_raise_i;
      if (taken_i == ACT_NMI)
        nmi_m_q <= 1'b1;
      else if (nmi_unmask_i)
        nmi_m_q <= 1'b0;
    end
  end

  assign smi_ok_o  = smi_p_q && !smi_block_i;
  assign init_ok_o = init_p_q && !init_block_i;
  assign nmi_ok_o  = nmi_p_q && !nmi_m_q;
endmodule

// File: rtl/evt_pick.sv
module evt_pick
  import evt_arb_pkg::*;
(
  input  logic [3:0] trap_nib_i,
  input  logic       gate_i,
  input  logic       smi_ok_i,
  input  logic       init_ok_i,
  input  logic       nmi_ok_i,
  input  logic       intr_ok_i,
  input  logic       lapic_i,
  input  logic       hold_i,
  input  logic       intr_blk_i,
  input  logic       dbg_blk_i,
  output act_e       act_o,
  output logic       trap_clr_o
);
  always_comb begin
    act_o      = ACT_NONE;
    trap_clr_o = 1'b0;
    if (trap_nib_i[3])
      act_o = ACT_DBG;
    else if (smi_ok_i && gate_i)
      act_o = ACT_SMM;
    else if (init_ok_i && gate_i)
      act_o = ACT_RST;
    else if (!dbg_blk_i && (|trap_nib_i))
      act_o = ACT_DBG;
    else begin
      trap_clr_o = !dbg_blk_i;
      if (!intr_blk_i && gate_i) begin
        if (nmi_ok_i)       act_o = ACT_NMI;
        else if (intr_ok_i) act_o = lapic_i ? ACT_ACK_LOC : ACT_ACK_LEG;
        else if (hold_i)    act_o = ACT_HLDA;
      end
    end
  end
endmodule

// File: rtl/evt_boundary_arbiter.sv
module evt_boundary_arbiter
  import evt_arb_pkg::*;
#(
  parameter int TRAP_W  = 16,
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic              ss_inh_i,
  input  logic              sti_inh_i,
  input  logic [TRAP_W-1:0] trap_set_i,
  input  logic              tf_i,
  input  logic              if_i,
  input  logic              gate_i,
  input  logic              smi_raise_i,
  input  logic              smi_block_i,
  input  logic              init_raise_i,
  input  logic              init_block_i,
  input  logic              nmi_raise_i,
  input  logic              nmi_unmask_i,
  input  logic              intr_i,
  input  logic              lapic_pend_i,
  input  logic              hold_req_i,
  output logic              dbg_exc_o,
  output logic              smm_enter_o,
  output logic              soft_rst_o,
  output logic              nmi_take_o,
  output logic [VEC_W-1:0]  nmi_vec_o,
  output logic              ack_lapic_o,
  output logic              ack_legacy_o,
  output logic              hlda_o,
  output logic              work_o
);
  localparam int                SS_BIT  = TRAP_W - 2;
  localparam logic [TRAP_W-1:0] SS_ONLY = TRAP_W'(1) << SS_BIT;
  localparam logic [VEC_W-1:0]  NMI_V   = VEC_W'(NMI_VEC);

  logic              bnd_q;
  logic [TRAP_W-1:0] trap_q, trap_f, trap_eval, trap_d;
  logic              intr_blk, dbg_blk;
  logic              smi_ok, init_ok, nmi_ok, intr_ok, trap_clr;
  act_e              pick, taken;

  evt_shadow u_shadow (
    .clk(clk), .rst(rst), .retire_i(retire_i), .ss_req_i(ss_inh_i),
    .sti_req_i(sti_inh_i), .intr_blk_o(intr_blk), .dbg_blk_o(dbg_blk)
  );

  evt_pending u_pend (
    .clk(clk), .rst(rst), .smi_raise_i(smi_raise_i), .smi_block_i(smi_block_i),
    .init_raise_i(init_raise_i), .init_block_i(init_block_i),
    .nmi_raise_i(nmi_raise_i), .nmi_unmask_i(nmi_unmask_i), .taken_i(taken),
    .smi_ok_o(smi_ok), .init_ok_o(init_ok), .nmi_ok_o(nmi_ok)
  );

  assign intr_ok = (intr_i || lapic_pend_i) && if_i;
  assign trap_f  = gate_i ? trap_q : (trap_q & SS_ONLY);

  evt_pick u_pick (
    .trap_nib_i(trap_f[TRAP_W-1 -: 4]), .gate_i(gate_i), .smi_ok_i(smi_ok),
    .init_ok_i(init_ok), .nmi_ok_i(nmi_ok), .intr_ok_i(intr_ok),
    .lapic_i(lapic_pend_i), .hold_i(hold_req_i), .intr_blk_i(intr_blk),
    .dbg_blk_i(dbg_blk), .act_o(pick), .trap_clr_o(trap_clr)
  );

  assign taken = bnd_q ? pick : ACT_NONE;

  always_comb begin
    trap_eval = (taken == ACT_DBG || trap_clr) ? '0 : trap_f;
    if (taken != ACT_DBG && tf_i)
      trap_eval = trap_eval | SS_ONLY;
    trap_d = (bnd_q ? trap_eval : trap_q) | (retire_i ? trap_set_i : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bnd_q        <= 1'b0;
      trap_q       <= '0;
      dbg_exc_o    <= 1'b0;
      smm_enter_o  <= 1'b0;
      soft_rst_o   <= 1'b0;
      nmi_take_o   <= 1'b0;
      nmi_vec_o    <= '0;
      ack_lapic_o  <= 1'b0;
      ack_legacy_o <= 1'b0;
      hlda_o       <= 1'b0;
      work_o       <= 1'b0;
    end else begin
      bnd_q        <= retire_i;
      trap_q       <= trap_d;
      dbg_exc_o    <= taken == ACT_DBG;
      smm_enter_o  <= taken == ACT_SMM;
      soft_rst_o   <= taken == ACT_RST;
      nmi_take_o   <= taken == ACT_NMI;
      nmi_vec_o    <= (taken == ACT_NMI) ? NMI_V : '0;
      ack_lapic_o  <= taken == ACT_ACK_LOC;
      ack_legacy_o <= taken == ACT_ACK_LEG;
      hlda_o       <= taken == ACT_HLDA;
      work_o       <= (gate_i && (smi_ok || init_ok || nmi_ok || intr_ok))
                      || (|trap_q) || hold_req_i;
    end
  end
endmodule

// File: rtl/evt_boundary_arbiter_chk.sv
module evt_boundary_arbiter_chk #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             retire_i,
  input logic             gate_i,
  input logic             if_i,
  input logic             intr_i,
  input logic             lapic_pend_i,
  input logic             hold_req_i,
  input logic             dbg_exc_o,
  input logic             smm_enter_o,
  input logic             soft_rst_o,
  input logic             nmi_take_o,
  input logic [VEC_W-1:0] nmi_vec_o,
  input logic             ack_lapic_o,
  input logic             ack_legacy_o,
  input logic             hlda_o
);
  logic [7:0] acts;
  assign acts = {dbg_exc_o, smm_enter_o, soft_rst_o, nmi_take_o,
                 ack_lapic_o, ack_legacy_o, hlda_o, 1'b0};

  // R1
  one_action_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(acts));
  // R1
  after_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (|acts) |-> $past(retire_i, 2));
  // R3
  smm_gate_chk: assert property (@(posedge clk) disable iff (rst)
    smm_enter_o |-> $past(gate_i));
  // R3
  init_gate_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> $past(gate_i));
  // R7
  nmi_vector_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_take_o |-> (nmi_vec_o == VEC_W'(NMI_VEC)));
  // R8
  ack_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_lapic_o || ack_legacy_o) |-> $past(if_i));
  // R8
  lapic_route_chk: assert property (@(posedge clk) disable iff (rst)
    ack_lapic_o |-> $past(lapic_pend_i));
  // R8
  legacy_route_chk: assert property (@(posedge clk) disable iff (rst)
    ack_legacy_o |-> $past(intr_i && !lapic_pend_i));
  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    hlda_o |-> $past(hold_req_i && gate_i));
endmodule

bind evt_boundary_arbiter evt_boundary_arbiter_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst(rst), .retire_i(retire_i), .gate_i(gate_i), .if_i(if_i),
  .intr_i(intr_i), .lapic_pend_i(lapic_pend_i), .hold_req_i(hold_req_i),
  .dbg_exc_o(dbg_exc_o), .smm_enter_o(smm_enter_o), .soft_rst_o(soft_rst_o),
  .nmi_take_o(nmi_take_o), .nmi_vec_o(nmi_vec_o), .ack_lapic_o(ack_lapic_o),
  .ack_legacy_o(ack_legacy_o), .hlda_o(hlda_o)
);

// File: tb/sim_evt_boundary_arbiter.sv
module sim_evt_boundary_arbiter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic retire_i = 0, ss_inh_i = 0, sti_inh_i = 0, tf_i = 0, if_i = 0, gate_i = 0;
  logic [15:0] trap_set_i = '0;
  logic smi_raise_i = 0, smi_block_i = 0, init_raise_i = 0, init_block_i = 0;
  logic nmi_raise_i = 0, nmi_unmask_i = 0, intr_i = 0, lapic_pend_i = 0, hold_req_i = 0;
  logic dbg_exc_o, smm_enter_o, soft_rst_o, nmi_take_o, ack_lapic_o, ack_legacy_o;
  logic hlda_o, work_o;
  logic [7:0] nmi_vec_o;

  evt_boundary_arbiter u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // codes: 0 none,1 dbg,2 smm,3 rst,4 nmi,5 lapic ack,6 legacy ack,7 hold, 15 several
  function automatic int act_code();
    int n = dbg_exc_o + smm_enter_o + soft_rst_o + nmi_take_o + ack_lapic_o
            + ack_legacy_o + hlda_o;
    if (n > 1) return 15;
    if (dbg_exc_o) return 1;
    if (smm_enter_o) return 2;
    if (soft_rst_o) return 3;
    if (nmi_take_o) return 4;
    if (ack_lapic_o) return 5;
    if (ack_legacy_o) return 6;
    if (hlda_o) return 7;
    return 0;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; retire_i = 0; ss_inh_i = 0; sti_inh_i = 0; trap_set_i = '0; tf_i = 0;
    if_i = 0; gate_i = 0; smi_block_i = 0; init_block_i = 0; nmi_unmask_i = 0;
    intr_i = 0; lapic_pend_i = 0; hold_req_i = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic raise(input logic s, input logic i, input logic n);
    smi_raise_i = s; init_raise_i = i; nmi_raise_i = n;
    @(negedge clk);
    smi_raise_i = 0; init_raise_i = 0; nmi_raise_i = 0;
  endtask

  // drive a retire, return two negedges later where the strobe is visible
  task automatic boundary(input logic ss, input logic sti, input logic [15:0] set);
    retire_i = 1; ss_inh_i = ss; sti_inh_i = sti; trap_set_i = set;
    @(negedge clk);
    retire_i = 0; ss_inh_i = 0; sti_inh_i = 0; trap_set_i = '0;
    @(negedge clk);
  endtask

  // flags: smi init nmi intr lapic ien gate tf hold ss sti | trap set | expected code
  localparam logic [30:0] VECS [25] = '{
    {11'b00000010000, 16'h0000, 4'd0},  // R1 idle
    {11'b10000010000, 16'h0000, 4'd2},  // R3 smi
    {11'b11100010000, 16'h0000, 4'd2},  // R2 smi first
    {11'b01100010000, 16'h0000, 4'd3},  // R2 init before nmi
    {11'b10000000000, 16'h0000, 4'd0},  // R3 smi gated
    {11'b01000000000, 16'h0000, 4'd0},  // R3 init gated
    {11'b00110110000, 16'h0000, 4'd4},  // R2 nmi before intr
    {11'b00100000000, 16'h0000, 4'd0},  // R6 nmi gated
    {11'b00011110000, 16'h0000, 4'd5},  // R8 lapic wins route
    {11'b00001110000, 16'h0000, 4'd5},  // R8 lapic alone
    {11'b00010110000, 16'h0000, 4'd6},  // R8 legacy
    {11'b00010010000, 16'h0000, 4'd0},  // R8 if clear
    {11'b00010110101, 16'h0000, 4'd0},  // R6 sti shadow blocks intr and hold
    {11'b00000010100, 16'h0000, 4'd7},  // R2 hold
    {11'b00000000100, 16'h0000, 4'd0},  // R6 hold gated
    {11'b10000010000, 16'h8000, 4'd1},  // R2 task switch before smi
    {11'b00100010000, 16'h1000, 4'd1},  // R5 breakpoint before nmi
    {11'b00000000000, 16'h1000, 4'd0},  // R4 breakpoint discarded
    {11'b00000000000, 16'h4000, 4'd1},  // R4 single step kept
    {11'b00010110010, 16'h1000, 4'd0},  // R9 ss shadow blocks debug and intr
    {11'b00100010001, 16'h1000, 4'd1},  // R9 sti shadow leaves debug
    {11'b00010100000, 16'h8000, 4'd0},  // R4 task switch discarded
    {11'b00100010001, 16'h0000, 4'd0},  // R9 sti shadow blocks nmi
    {11'b00010110000, 16'h0001, 4'd6},  // R5 low bits do not fire
    {11'b00010110100, 16'h0000, 4'd6}   // R2 intr before hold
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R13 reset state
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R13 strobes in reset", act_code(), 0);
    chk("R13 work in reset", work_o, 0);
    do_reset();
    chk("R13 vector after reset", nmi_vec_o, 0);

    for (int i = 0; i < 25; i++) begin
      logic [30:0] v = VECS[i];
      do_reset();
      intr_i = v[27]; lapic_pend_i = v[26]; if_i = v[25]; gate_i = v[24];
      tf_i = v[23]; hold_req_i = v[22];
      raise(v[30], v[29], v[28]);
      boundary(v[21], v[20], v[19:4]);
      chk($sformatf("R2 table row %0d", i), act_code(), int'(v[3:0]));
      if (v[3:0] == 4'd4) chk("R7 vector", nmi_vec_o, 2);
    end

    // R9 shadow lasts one instruction
    do_reset(); gate_i = 1; if_i = 1; intr_i = 1;
    boundary(0, 1, 16'h0); chk("R9 sti shadow boundary", act_code(), 0);
    boundary(0, 0, 16'h0); chk("R9 shadow expired", act_code(), 6);

    // R10 second stack load does not re-arm
    do_reset(); gate_i = 1; if_i = 1; intr_i = 1;
    boundary(1, 0, 16'h0); chk("R10 first ss shadow", act_code(), 0);
    boundary(1, 0, 16'h0); chk("R10 second ss ignored", act_code(), 6);
    do_reset(); gate_i = 1; if_i = 1; intr_i = 1;
    boundary(0, 1, 16'h0); chk("R10 sti first", act_code(), 0);
    boundary(0, 1, 16'h0); chk("R10 sti re-arms", act_code(), 0);

    // R7 nmi masking and unmask
    do_reset(); gate_i = 1;
    raise(0, 0, 1);
    boundary(0, 0, 16'h0); chk("R7 nmi taken", act_code(), 4);
    chk("R7 nmi vector", nmi_vec_o, 2);
    raise(0, 0, 1);
    boundary(0, 0, 16'h0); chk("R7 nmi masked", act_code(), 0);
    nmi_unmask_i = 1; @(negedge clk); nmi_unmask_i = 0;
    boundary(0, 0, 16'h0); chk("R7 nmi after unmask", act_code(), 4);

    // R11 trap flag schedules single step
    do_reset(); gate_i = 1; tf_i = 1;
    boundary(0, 0, 16'h0); chk("R11 tf boundary", act_code(), 0);
    tf_i = 0;
    boundary(0, 0, 16'h0); chk("R11 step fires", act_code(), 1);
    boundary(0, 0, 16'h0); chk("R5 trap cleared after exception", act_code(), 0);

    // R12 work flag from a non-firing trap bit, cleared by evaluation (R5)
    do_reset(); gate_i = 1;
    boundary(0, 0, 16'h0001);
    chk("R12 work with trap bit", work_o, 1);
    @(negedge clk);
    chk("R5 register cleared, work drops", work_o, 0);

    // R3 gated smi held, then taken once; R12 gate qualifies work
    do_reset();
    raise(1, 0, 0);
    boundary(0, 0, 16'h0); chk("R3 smi held while gated", act_code(), 0);
    chk("R12 work gated", work_o, 0);
    gate_i = 1; @(negedge clk);
    chk("R12 work with smi", work_o, 1);
    boundary(0, 0, 16'h0); chk("R3 smi taken", act_code(), 2);
    boundary(0, 0, 16'h0); chk("R3 smi pending cleared", act_code(), 0);

    // R3 init raise ignored while blocked; init taken once
    do_reset(); gate_i = 1; init_block_i = 1;
    raise(0, 1, 0);
    init_block_i = 0;
    boundary(0, 0, 16'h0); chk("R3 blocked init ignored", act_code(), 0);
    raise(0, 1, 0);
    boundary(0, 0, 16'h0); chk("R3 init soft reset", act_code(), 3);
    boundary(0, 0, 16'h0); chk("R3 init pending cleared", act_code(), 0);

    // R12 hold request drives work
    do_reset(); hold_req_i = 1; @(negedge clk);
    chk("R12 work with hold", work_o, 1);

    // R1 one action per boundary, then wait for retire
    do_reset(); gate_i = 1;
    raise(1, 0, 1);
    boundary(0, 0, 16'h0); chk("R1 first action", act_code(), 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R1 idle without retire", act_code(), 0);
    end
    boundary(0, 0, 16'h0); chk("R1 next boundary", act_code(), 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule